// File: doc/BRIEF.md
# PCI Bridge Window Register Bank

This block is the programmable register file of a PCI host bridge. It keeps four address window sets, each with a base register, a mask register and a translated base register, plus one bridge control register. Software reaches these registers through a simple request/response port. The window registers and the control register are also driven out as flat buses, so that a neighbouring translation unit can use them to map bus addresses.

Only full 64-bit accesses are served. Each register occupies a 64-byte slot, so the register index is the byte offset divided by 64. A small set of status and maintenance slots have fixed behaviour: they read as zero, and a write to them is either dropped or rejected. Any access the block does not support returns an error flag alongside the response, and it changes no state.

Top module: `pci_window_regs`

## Requirements
- R1: After reset all twelve window registers read as zero, and the control register reads 0x0000_0021_0010_0000 (bit 20 set, bit 32 set, bits 39:36 equal to 2).
- R2: The register index is `req_addr >> 6`, so the low six address bits are ignored. Indices 0..3 select the window bases, 4..7 the window masks, 8..11 the translated bases, and 12 the control register. The higher slots are 13 latency, 14 reserved, 15 error status, 16 error mask, 17 error set, 18 single invalidate, 19 invalidate-all, 20 monitor control and 21 monitor count.
- R3: `req_size` encodes 0=1 byte, 1=2 bytes, 2=4 bytes and 3=8 bytes. Any size other than 3 returns `rsp_err`=1 and zero data, and it alters no register, even when it targets a valid slot.
- R4: A legal 64-bit write to indices 0..11 replaces the whole register, and a later read returns the new value. The value appears on `win_base_o`, `win_mask_o` or `win_xlat_o` (window i in bits 64*i+63:64*i) in the cycle after the write. Reads and idle cycles change no register.
- R5: A legal write to index 12 replaces all 64 bits of the control register, which is shown on `ctrl_o` from the next cycle.
- R6: Index 15 reads as zero without error. A write to it completes without error and has no effect.
- R7: Index 16 reads as zero without error. A write to it returns `rsp_err`=1.
- R8: Index 19 reads as zero without error. A write to it completes without error, and its data changes no register.
- R9: Indices 13, 14, 17, 18, 20, 21 and every index from 22 upward return `rsp_err`=1 on both reads and writes, and change no register.
- R10: Every request cycle produces exactly one `rsp_valid` pulse in the following cycle. `rsp_rdata` is zero for writes and for errored accesses. A request is accepted in every cycle, so back-to-back requests are allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset from the block base |
| req_size | input | 2 | Access size code |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Unsupported access flag |
| rsp_rdata | output | 64 | Read data |
| win_base_o | output | 64*NWIN | Window base registers |
| win_mask_o | output | 64*NWIN | Window mask registers |
| win_xlat_o | output | 64*NWIN | Translated base registers |
| ctrl_o | output | 64 | Bridge control register |

## Verification
Two things can land in the same cycle: the response to one request and the arrival of the next request, which may be a read of the register that was just written. The bench issues write-then-read pairs with no idle cycle between them. It expects the read to return the freshly written value, and it expects the exported bus to change exactly one cycle after the write. A behavioural model predicts the response and every exported register on each clock, and any difference in any cycle is reported.

// File: rtl/pci_window_regs.sv
module pci_window_regs #(
  parameter int NWIN   = 4,
  parameter int ADDR_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [1:0]           req_size,
  input  logic [63:0]          req_wdata,
  output logic                 rsp_valid,
  output logic                 rsp_err,
  output logic [63:0]          rsp_rdata,
  output logic [64*NWIN-1:0]   win_base_o,
  output logic [64*NWIN-1:0]   win_mask_o,
  output logic [64*NWIN-1:0]   win_xlat_o,
  output logic [63:0]          ctrl_o
);

  localparam int IDX_CTRL  = 3*NWIN;
  localparam int IDX_PERR  = 3*NWIN + 3;
  localparam int IDX_PMASK = 3*NWIN + 4;
  localparam int IDX_INVAL = 3*NWIN + 7;
  localparam logic [63:0] CTRL_RST = (64'd1 << 20) | (64'd1 << 32) | (64'd2 << 36);

  logic [63:0] base_q [NWIN];
  logic [63:0] mask_q [NWIN];
  logic [63:0] xlat_q [NWIN];
  logic [63:0] ctrl_q;

  logic [ADDR_W-1:0] idx;
  logic [NWIN-1:0]   sel_base, sel_mask, sel_xlat;
  logic              sel_ctrl, dec_ok, acc_ok, do_wr;
  logic [63:0]       dec_rdata;

  assign idx = req_addr >> 6;

  always_comb begin
    sel_base  = '0;
    sel_mask  = '0;
    sel_xlat  = '0;
    sel_ctrl  = 1'b0;
    dec_ok    = 1'b0;
    dec_rdata = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (idx == ADDR_W'(i)) begin
        sel_base[i] = 1'b1; dec_ok = 1'b1; dec_rdata = base_q[i];
      end
      if (idx == ADDR_W'(i + NWIN)) begin
        sel_mask[i] = 1'b1; dec_ok = 1'b1; dec_rdata = mask_q[i];
      end
      if (idx == ADDR_W'(i + 2*NWIN)) begin
        sel_xlat[i] = 1'b1; dec_ok = 1'b1; dec_rdata = xlat_q[i];
      end
    end
    if (idx == ADDR_W'(IDX_CTRL)) begin
      sel_ctrl = 1'b1; dec_ok = 1'b1; dec_rdata = ctrl_q;
    end
    if (idx == ADDR_W'(IDX_PERR))  dec_ok = 1'b1;
    if (idx == ADDR_W'(IDX_PMASK)) dec_ok = !req_write;
    if (idx == ADDR_W'(IDX_INVAL)) dec_ok = 1'b1;
  end

  assign acc_ok = (req_size == 2'd3) && dec_ok;
  assign do_wr  = req_valid && req_write && acc_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWIN; i++) begin
        base_q[i] <= '0;
        mask_q[i] <= '0;
        xlat_q[i] <= '0;
      end
      ctrl_q <= CTRL_RST;
    end else if (do_wr) begin
      for (int i = 0; i < NWIN; i++) begin
        if (sel_base[i]) base_q[i] <= req_wdata;
        if (sel_mask[i]) mask_q[i] <= req_wdata;
        if (sel_xlat[i]) xlat_q[i] <= req_wdata;
      end
      if (sel_ctrl) ctrl_q <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && !acc_ok;
      rsp_rdata <= (req_valid && !req_write && acc_ok) ? dec_rdata : '0;
    end
  end

  for (genvar g = 0; g < NWIN; g++) begin : g_export
    assign win_base_o[64*g +: 64] = base_q[g];
    assign win_mask_o[64*g +: 64] = mask_q[g];
    assign win_xlat_o[64*g +: 64] = xlat_q[g];
  end
  assign ctrl_o = ctrl_q;

  AST_NARROW_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_size != 2'd3 |=> rsp_valid && rsp_err && rsp_rdata == '0); // R3
  AST_NARROW_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_size != 2'd3 |=> $stable(ctrl_o) && $stable(win_base_o)
      && $stable(win_mask_o) && $stable(win_xlat_o)); // R3
  AST_NO_WRITE_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> $stable(ctrl_o) && $stable(win_base_o)
      && $stable(win_mask_o) && $stable(win_xlat_o)); // R4
  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && req_size == 2'd3 && (req_addr >> 6) == ADDR_W'(IDX_CTRL)
      |=> ctrl_o == $past(req_wdata)); // R5
  AST_PMASK_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && (req_addr >> 6) == ADDR_W'(IDX_PMASK) |=> rsp_err); // R7
  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R10
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !rsp_err); // R10
  AST_ERR_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_rdata == '0); // R10

endmodule

// File: tb/pci_window_regs_bench.sv
`timescale 1ns/1ps
module pci_window_regs_bench;
  localparam int NWIN = 4;
  localparam int AW   = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_size = 2'd3;
  logic [63:0] req_wdata = '0;
  logic rsp_valid, rsp_err;
  logic [63:0] rsp_rdata, ctrl_o;
  logic [64*NWIN-1:0] win_base_o, win_mask_o, win_xlat_o;

  pci_window_regs #(.NWIN(NWIN), .ADDR_W(AW)) u_pci_window_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .win_base_o(win_base_o), .win_mask_o(win_mask_o), .win_xlat_o(win_xlat_o),
    .ctrl_o(ctrl_o));

  always #10 clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 1'b0;
  string cur_tag = "R1";

  logic [63:0] m_reg [13];
  bit e_valid = 0, e_err = 0;
  logic [63:0] e_rdata = '0;

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", cur_tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("rsp_valid", 64'(rsp_valid), 64'(e_valid));
    chk("rsp_err", 64'(rsp_err), 64'(e_err));
    chk("rsp_rdata", rsp_rdata, e_rdata);
    chk("ctrl_o", ctrl_o, m_reg[12]);
    for (int i = 0; i < NWIN; i++) begin
      chk("win_base_o", win_base_o[64*i +: 64], m_reg[i]);
      chk("win_mask_o", win_mask_o[64*i +: 64], m_reg[i+4]);
      chk("win_xlat_o", win_xlat_o[64*i +: 64], m_reg[i+8]);
    end
  endtask

  task automatic step(bit v, bit w, int idx, int low, logic [1:0] sz,
                      logic [63:0] d, string tag);
    bit ok;
    @(negedge clk);
    compare_all();
    cur_tag   = tag;
    req_valid = v; req_write = w;
    req_addr  = AW'(idx * 64 + low);
    req_size  = sz; req_wdata = d;
    ok = (sz == 2'd3) && ((idx <= 12) || idx == 15 || idx == 19 || (idx == 16 && !w));
    e_valid = v;
    e_err   = v && !ok;
    e_rdata = (v && !w && ok && idx <= 12) ? m_reg[idx] : 64'd0;
    if (v && w && ok && idx <= 12) m_reg[idx] = d;
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, 0, 2'd3, 64'd0, tag);
  endtask

  initial begin
    for (int i = 0; i < 12; i++) m_reg[i] = 64'd0;
    m_reg[12] = 64'h0000_0021_0010_0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R1");
    for (int i = 0; i <= 12; i++) step(1, 0, i, 0, 2'd3, 64'd0, "R1");
    for (int i = 0; i < 12; i++)
      step(1, 1, i, 0, 2'd3, {32'hA5A5_0000 + 32'(i), 32'h1234_5600 + 32'(i * 17)}, "R4");
    for (int i = 0; i < 12; i++) step(1, 0, i, 0, 2'd3, 64'd0, "R4");
    step(1, 1, 5, 6'h28, 2'd3, 64'hFFFF_0000_FFFF_0001, "R2");
    step(1, 0, 5, 6'h3F, 2'd3, 64'd0, "R2");
    step(1, 0, 9, 6'h01, 2'd3, 64'd0, "R2");
    idle("R4");
    step(1, 1, 12, 0, 2'd3, 64'hDEAD_BEEF_0BAD_F00D, "R5");
    step(1, 0, 12, 0, 2'd3, 64'd0, "R5");
    for (int s = 0; s < 3; s++) begin
      step(1, 1, 0, 0, 2'(s), 64'h1111_2222_3333_4444, "R3");
      step(1, 1, 12, 0, 2'(s), 64'h0, "R3");
      step(1, 0, 3, 0, 2'(s), 64'h0, "R3");
    end
    step(1, 0, 0, 0, 2'd3, 64'd0, "R3");
    step(1, 1, 15, 0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, "R6");
    step(1, 0, 15, 0, 2'd3, 64'd0, "R6");
    step(1, 0, 16, 0, 2'd3, 64'd0, "R7");
    step(1, 1, 16, 0, 2'd3, 64'h55, "R7");
    step(1, 0, 16, 0, 2'd3, 64'd0, "R7");
    step(1, 1, 19, 0, 2'd3, 64'h7777, "R8");
    step(1, 0, 19, 0, 2'd3, 64'd0, "R8");
    foreach (m_reg[k]) if (k == 0) step(1, 0, 19, 0, 2'd3, 64'd0, "R8");
    begin
      int bad [10] = '{13, 14, 17, 18, 20, 21, 22, 40, 63, 33};
      foreach (bad[k]) begin
        step(1, 1, bad[k], 0, 2'd3, 64'hCAFE_0000 + 64'(k), "R9");
        step(1, 0, bad[k], 0, 2'd3, 64'd0, "R9");
      end
    end
    for (int i = 0; i < 4; i++) begin
      step(1, 1, i * 3, 0, 2'd3, 64'h0F0F_0000_0000_0000 + 64'(i), "R10");
      step(1, 0, i * 3, 0, 2'd3, 64'd0, "R10");
    end
    step(1, 1, 12, 0, 2'd3, 64'h0, "R10");
    step(1, 1, 12, 0, 2'd3, 64'h1, "R10");
    step(1, 0, 12, 0, 2'd3, 64'd0, "R10");
    idle("R10");
    idle("R10");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=5000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule